// File: doc/BRIEF.md
# Low-Power Residency Tenure Histogram

This block measures how long a cache stays in each low-power residency. A residency is an interval in which the low-power-active level is high. Its length, the tenure, is the number of reference ticks counted during that interval. The reference ticks arrive as a one-cycle enable at 19.2 MHz and are already synchronous to the system clock. The block keeps a running tenure for the residency in progress and a cumulative tenure total across all residencies.

When a residency finishes, its tenure is compared with two programmable limits, a low threshold and a mid threshold. Exactly one of three occurrence counters (low, mid or high) then advances, and the three counters together form a histogram of residency lengths. A residency that saw no tick falls into no bin. Software reads the counters as plain outputs. A synchronous clear resets the total and the histogram, but leaves the running tenure alone.

Top module: `lp_tenure_hist`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, every output is zero.
- R2: A residency starts in the first cycle in which the low-power level is high after having been low. In that start cycle the tenure restarts from zero and counts that cycle's tick if there is one. Each further tick adds one while the level stays high, and a tick in the first cycle after the level falls (the end cycle) is also counted. The tenure output reflects each counted tick one cycle later and holds the final value until the next residency starts.
- R3: The total output adds one for every tick that R2 counts, summed over all residencies. Ticks while the block is idle are not counted.
- R4: A residency whose final tenure is zero increments no occurrence counter.
- R5: A residency whose final tenure is at least 1 and at most the low threshold increments the low counter.
- R6: A residency whose final tenure is above the low threshold and at most the mid threshold increments the mid counter.
- R7: A residency whose final tenure is above the mid threshold increments the high counter.
- R8: The low test is applied before the mid test. When the low threshold exceeds the mid threshold, no residency reaches the mid bin, and tenures above the low threshold go to the high bin.
- R9: The thresholds are read only in the end cycle. Values present earlier in the residency have no effect on its bin.
- R10: The tenure, the total and the three occurrence counters stop at their all-ones value instead of wrapping.
- R11: A clear pulse zeroes the total and all three occurrence counters on the next edge. It takes priority over any increment in the same cycle and leaves the tenure output unchanged.
- R12: The occurrence counters change only on the edge that closes an end cycle, or on a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle reference tick enable |
| lp_active_i | input | 1 | Low-power residency level |
| thr_low_i | input | TEN_W | Low threshold |
| thr_mid_i | input | TEN_W | Mid threshold |
| clear_i | input | 1 | Zero total and occurrence counters |
| tenure_o | output | TEN_W | Tenure of current or last residency |
| total_o | output | TOT_W | Cumulative tenure |
| occ_low_o | output | OCC_W | Low-bin occurrence count |
| occ_mid_o | output | OCC_W | Mid-bin occurrence count |
| occ_high_o | output | OCC_W | High-bin occurrence count |

## Verification
The hardest case to reach from the ports is a tick that arrives in the end cycle together with a threshold change and, in some cases, a clear. All three meet in a single cycle that exists only once per residency. The bench builds every residency from a task that holds deliberately wrong thresholds while the level is high and puts the real thresholds on the inputs only in the end cycle. It optionally moves the last tick into that end cycle, and optionally asserts clear there as well. It sweeps every tenure from 0 past the saturation point against every low and mid pair in a small range, including pairs where low exceeds mid, and computes each bin and total arithmetically.

// File: rtl/lp_tenure_pkg.sv
package lp_tenure_pkg;
   typedef enum logic [1:0] {
      BIN_NONE = 2'd0,
      BIN_LOW  = 2'd1,
      BIN_MID  = 2'd2,
      BIN_HIGH = 2'd3
   } tbin_e;

   localparam int NUM_BINS = 3;
endpackage

// File: rtl/lp_sat_counter.sv
module lp_sat_counter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   localparam logic [W-1:0] MAXV = {W{1'b1}};

   initial begin
      if (W < 1) $error("lp_sat_counter: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                     cnt <= '0;
      else if (clr)                   cnt <= '0;
      else if (inc && (cnt != MAXV))  cnt <= cnt + 1'b1;
   end

   // R10
   hold_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt == MAXV) && !clr |=> cnt == MAXV);

   // R11
   clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);

   // R3
   step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/lp_tenure_track.sv
module lp_tenure_track #(
   parameter int TEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             lp_active_i,
   output logic             counted_o,
   output logic             res_end_o,
   output logic [TEN_W-1:0] fin_o,
   output logic [TEN_W-1:0] tenure_o
);
   localparam logic [TEN_W-1:0] MAXV = {TEN_W{1'b1}};

   logic lp_q;
   logic start_c;
   logic [TEN_W-1:0] next_c;

   assign counted_o = tick_i && (lp_active_i || lp_q);
   assign start_c   = lp_active_i && !lp_q;
   assign res_end_o = lp_q && !lp_active_i;
   assign next_c    = (counted_o && (tenure_o != MAXV)) ? tenure_o + 1'b1 : tenure_o;
   assign fin_o     = next_c;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lp_q     <= 1'b0;
         tenure_o <= '0;
      end else begin
         lp_q <= lp_active_i;
         if (start_c)                    tenure_o <= {{(TEN_W-1){1'b0}}, tick_i};
         else if (lp_active_i || lp_q)   tenure_o <= next_c;
      end
   end

   // R2
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lp_active_i && !lp_q |=> $stable(tenure_o));

   // R10
   ten_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tenure_o == MAXV) && lp_q |=> tenure_o == MAXV);
endmodule

// File: rtl/lp_bin_classify.sv
module lp_bin_classify
   import lp_tenure_pkg::*;
#(
   parameter int TEN_W = 16
) (
   input  logic [TEN_W-1:0] fin_i,
   input  logic [TEN_W-1:0] thr_low_i,
   input  logic [TEN_W-1:0] thr_mid_i,
   output tbin_e            bin_o
);
   always_comb begin
      if (fin_i == '0)             bin_o = BIN_NONE;
      else if (fin_i <= thr_low_i) bin_o = BIN_LOW;
      else if (fin_i <= thr_mid_i) bin_o = BIN_MID;
      else                         bin_o = BIN_HIGH;
   end
endmodule

// File: rtl/lp_tenure_hist.sv
module lp_tenure_hist
   import lp_tenure_pkg::*;
#(
   parameter int TEN_W = 16,
   parameter int TOT_W = 32,
   parameter int OCC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             lp_active_i,
   input  logic [TEN_W-1:0] thr_low_i,
   input  logic [TEN_W-1:0] thr_mid_i,
   input  logic             clear_i,
   output logic [TEN_W-1:0] tenure_o,
   output logic [TOT_W-1:0] total_o,
   output logic [OCC_W-1:0] occ_low_o,
   output logic [OCC_W-1:0] occ_mid_o,
   output logic [OCC_W-1:0] occ_high_o
);
   initial begin
      if (TEN_W < 2)     $error("lp_tenure_hist: TEN_W must be at least 2");
      if (TOT_W < TEN_W) $error("lp_tenure_hist: TOT_W must not be below TEN_W");
      if (OCC_W < 1)     $error("lp_tenure_hist: OCC_W must be at least 1");
   end

   logic             counted;
   logic             res_end;
   logic [TEN_W-1:0] fin;
   tbin_e            bin;
   logic [OCC_W-1:0] occ [NUM_BINS];

   lp_tenure_track #(.TEN_W(TEN_W)) u_track (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick_i      (tick_i),
      .lp_active_i (lp_active_i),
      .counted_o   (counted),
      .res_end_o   (res_end),
      .fin_o       (fin),
      .tenure_o    (tenure_o)
   );

   lp_bin_classify #(.TEN_W(TEN_W)) u_class (
      .fin_i     (fin),
      .thr_low_i (thr_low_i),
      .thr_mid_i (thr_mid_i),
      .bin_o     (bin)
   );

   lp_sat_counter #(.W(TOT_W)) u_total (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clear_i),
      .inc   (counted),
      .cnt   (total_o)
   );

   for (genvar g = 0; g < NUM_BINS; g++) begin : g_occ
      lp_sat_counter #(.W(OCC_W)) u_occ (
         .clk   (clk),
         .rst_n (rst_n),
         .clr   (clear_i),
         .inc   (res_end && (bin == tbin_e'(g + 1))),
         .cnt   (occ[g])
      );
   end

   assign occ_low_o  = occ[0];
   assign occ_mid_o  = occ[1];
   assign occ_high_o = occ[2];

   // R12
   occ_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_end && !clear_i |=> $stable(occ_low_o) && $stable(occ_mid_o) && $stable(occ_high_o));

   // R4
   zero_no_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
      res_end && (fin == '0) |=> $stable(occ_low_o) && $stable(occ_mid_o) && $stable(occ_high_o));
endmodule

// File: tb/tb_lp_tenure_hist.sv
module tb_lp_tenure_hist;
   localparam int TW = 4;
   localparam int SW = 8;
   localparam int OW = 8;
   localparam int TMAX = 15;
   localparam int SMAX = 255;
   localparam int OMAX = 255;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic tick = 1'b0;
   logic lp = 1'b0;
   logic clr = 1'b0;
   logic [TW-1:0] thr_lo = '0;
   logic [TW-1:0] thr_mi = '0;
   logic [TW-1:0] ten;
   logic [SW-1:0] tot;
   logic [OW-1:0] o_lo, o_mi, o_hi;

   int checks = 0;
   int fails = 0;
   int e_tot = 0, e_lo = 0, e_mi = 0, e_hi = 0;

   always #2 clk = ~clk;

   lp_tenure_hist #(.TEN_W(TW), .TOT_W(SW), .OCC_W(OW)) dut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick), .lp_active_i(lp),
      .thr_low_i(thr_lo), .thr_mid_i(thr_mi), .clear_i(clr),
      .tenure_o(ten), .total_o(tot),
      .occ_low_o(o_lo), .occ_mid_o(o_mi), .occ_high_o(o_hi)
   );

   task automatic chk(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input int e_ten, input string tag);
      chk(int'(ten), e_ten, {tag, " tenure"});
      chk(int'(tot), e_tot, {tag, " total"});
      chk(int'(o_lo), e_lo, {tag, " occ_low"});
      chk(int'(o_mi), e_mi, {tag, " occ_mid"});
      chk(int'(o_hi), e_hi, {tag, " occ_high"});
   endtask

   // one residency; wrong thresholds while high, real ones only in end cycle (R9)
   task automatic residency(input int n, input int sp, input bit tail,
                            input int lo, input int mi, input bit clr_end);
      int hi_ticks;
      int cyc;
      int fin;
      hi_ticks = (tail && n > 0) ? n - 1 : n;
      cyc = (hi_ticks * sp == 0) ? 1 : hi_ticks * sp;
      thr_lo = TW'(TMAX - lo);
      thr_mi = TW'(TMAX - mi);
      for (int c = 0; c < cyc; c++) begin
         lp = 1'b1;
         tick = (c % sp == sp - 1) && (c / sp < hi_ticks);
         @(negedge clk);
      end
      lp = 1'b0;
      tick = tail && n > 0;
      thr_lo = TW'(lo);
      thr_mi = TW'(mi);
      clr = clr_end;
      @(negedge clk);
      tick = 1'b0;
      clr = 1'b0;
      fin = (n > TMAX) ? TMAX : n;
      if (clr_end) begin
         e_tot = 0; e_lo = 0; e_mi = 0; e_hi = 0;
      end else begin
         e_tot = (e_tot + n > SMAX) ? SMAX : e_tot + n;
         if (fin == 0) ;
         else if (fin <= lo) e_lo = (e_lo == OMAX) ? OMAX : e_lo + 1;
         else if (fin <= mi) e_mi = (e_mi == OMAX) ? OMAX : e_mi + 1;
         else                e_hi = (e_hi == OMAX) ? OMAX : e_hi + 1;
      end
      chk_all(fin, "R2 R3 R4 R5 R6 R7 R8 R9 R10 R12 residency");
   endtask

   task automatic do_clear(input int e_ten);
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      e_tot = 0; e_lo = 0; e_mi = 0; e_hi = 0;
      chk_all(e_ten, "R11 idle clear");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      lp = 1'b1;
      tick = 1'b1;
      repeat (3) @(negedge clk);
      chk_all(0, "R1 in reset");
      lp = 1'b0;
      tick = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_all(0, "R1 after reset");

      // R3: idle ticks are not counted
      tick = 1'b1;
      repeat (3) @(negedge clk);
      tick = 1'b0;
      @(negedge clk);
      chk_all(0, "R3 idle ticks");

      // sweep thresholds, tenures, spacings, end-cycle tick
      for (int lo = 0; lo < 6; lo++) begin
         for (int mi = 0; mi < 6; mi++) begin
            do_clear(int'(ten));
            for (int n = 0; n < 18; n++) begin
               residency(n, 1 + (n % 2), (n % 3) == 0, lo, mi, 1'b0);
               @(negedge clk);
            end
         end
      end

      // R11: clear in end cycle wins over increments; tenure kept
      residency(4, 1, 1'b1, 2, 8, 1'b0);
      residency(6, 1, 1'b1, 2, 8, 1'b1);
      chk(int'(ten), 6, "R11 tenure kept on clear");

      // R2: tenure holds after residency
      repeat (5) @(negedge clk);
      chk(int'(ten), 6, "R2 tenure hold idle");

      // R10: occurrence and total saturation
      for (int k = 0; k < 260; k++) residency(1, 1, 1'b0, 1, 2, 1'b0);
      chk(int'(o_lo), OMAX, "R10 occ saturation");
      chk(int'(tot), SMAX, "R10 total saturation");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule